// File: doc/BRIEF.md
# Register-Mapped SPI Command Engine

This block is a byte-wide SPI master that runs one flash-style command each time the host triggers it. On the host side it has a small register bus with a write strobe, a read strobe, a 4-bit address and 8-bit data. On the device side it drives the serial clock, the active-low chip select and the serial output, and it samples the serial input. The command byte has its own register. Up to eight data bytes, both outgoing and incoming, share one small buffer. The host reaches that buffer through a single data port whose entry pointer moves on every access and can be cleared.

To run a command the host writes the byte counts and the command byte. It then clears the pointer, writes the outgoing bytes and clears the pointer again. Next it sets the start bit and polls the busy flag. When the command has finished, incoming bytes sit in the buffer directly after the outgoing ones. The host clears the pointer, reads past the outgoing entries and then reads the incoming data.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the registers at 0x0, 0x1, 0x2, 0x3 and 0xD all read 0x00.
- R2: The command byte in register 0x0 is always the first byte of a command, sent MSB first in SPI mode 0. The clock idles low, the output is stable at every rising edge, and input is sampled on rising edges.
- R3: After the command byte, the engine sends one outgoing byte per count taken from the low nibble of register 0x1 (bits [3:0]). These bytes come from buffer entries 0, 1, 2 and so on, in that order.
- R4: The receive phase clocks one byte per count in the high nibble of register 0x1 (bits [7:4]). During this phase the serial output sends zeros. Incoming byte k is stored in buffer entry (tx_count + k) mod 8.
- R5: Chip select goes low once per command and stays low until the last bit has been received. Each command gives exactly 8 × (1 + tx_count + rx_count) rising clock edges.
- R6: A write or read of the data port at 0xC accesses the entry at the pointer, then advances the pointer modulo 8. The pointer reads back in bits [2:0] of register 0xD.
- R7: Writing 1 to bit 4 of register 0x2 clears the pointer to 0.
- R8: Writing 1 to bit 0 of register 0x2 starts a command. That bit reads 1 while the command runs and clears itself when the command ends. Bit 7 of register 0x3 reads 1 for the whole transaction.
- R9: While a command runs, the engine ignores writes to 0x0, 0x1, the data port and 0x2. The stored values and the pointer stay unchanged.
- R10: With a tx_count of zero, the host programs rx_count as n+1 and reads n bytes starting at entry 0. These are the first n incoming bytes.
- R11: When tx_count + rx_count is larger than 8, incoming bytes wrap around and overwrite the lowest entries.
- R12: Consecutive rising edges of the serial clock within a command are 2 × HALF_DIV system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pointer at 0xC) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is the wrap of incoming bytes over outgoing entries. It only appears when the combined byte count exceeds the buffer depth. It is also invisible until the host reads all eight entries back after the command. The stimulus loads six outgoing bytes, requests four incoming ones, and then reads the whole buffer. This shows old outgoing data in the middle entries and new incoming data at both ends. A second hard case is writing to every register while the transfer runs. The bench issues those writes between its polls of the busy flag, and checks after completion that nothing moved.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_OPCODE = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_COUNTS = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_DATA   = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_PTR    = 4'hD;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_PRST_BIT  = 4;
    localparam int STAT_BUSY_BIT  = 7;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_SHIFT
    } seq_state_e;

endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_we,
    input  logic [PTR_W-1:0]  eng_widx,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic [PTR_W-1:0]  eng_ridx,
    output logic [DATA_W-1:0] eng_rdata
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (host_we) begin
            mem_d[host_idx] = host_wdata;
        end
        if (eng_we) begin
            mem_d[eng_widx] = eng_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign host_rdata = mem_q[host_idx];
    assign eng_rdata  = mem_q[eng_ridx];

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    output logic [DATA_W-1:0] opcode,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic              go,
    output logic              host_we,
    output logic [PTR_W-1:0]  host_ptr,
    input  logic [DATA_W-1:0] host_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] opcode;
        logic [DATA_W-1:0] counts;
        logic [PTR_W-1:0]  ptr;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ok;
    logic data_acc;

    always_comb begin
        r_d      = r_q;
        go       = 1'b0;
        wr_ok    = reg_wr && !busy;
        host_we  = wr_ok && (reg_addr == ADR_DATA);
        data_acc = host_we || (reg_rd && (reg_addr == ADR_DATA));

        if (data_acc) begin
            r_d.ptr = r_q.ptr + 1'b1;
        end
        if (wr_ok) begin
            unique case (reg_addr)
                ADR_OPCODE: r_d.opcode = reg_wdata;
                ADR_COUNTS: r_d.counts = reg_wdata;
                ADR_CTRL: begin
                    if (reg_wdata[CTRL_PRST_BIT]) begin
                        r_d.ptr = '0;
                    end
                    go = reg_wdata[CTRL_GO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_OPCODE: reg_rdata = r_q.opcode;
            ADR_COUNTS: reg_rdata = r_q.counts;
            ADR_CTRL:   reg_rdata[CTRL_GO_BIT]   = busy;
            ADR_STATUS: reg_rdata[STAT_BUSY_BIT] = busy;
            ADR_DATA:   reg_rdata = host_rdata;
            ADR_PTR:    reg_rdata[PTR_W-1:0] = r_q.ptr;
            default:    reg_rdata = '0;
        endcase
    end

    assign opcode   = r_q.opcode;
    assign tx_cnt   = r_q.counts[CNT_W-1:0];
    assign rx_cnt   = r_q.counts[2*CNT_W-1:CNT_W];
    assign host_ptr = r_q.ptr;

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int IDX_W  = CNT_W + 1,
    localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
    localparam int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] opcode,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    output logic [PTR_W-1:0]  buf_ridx,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [PTR_W-1:0]  buf_widx,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              busy,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    typedef struct packed {
        seq_state_e        st;
        logic [DIV_W-1:0]  div;
        logic              sclk;
        logic              cs_n;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [BIT_W-1:0]  bitn;
        logic [IDX_W-1:0]  byten;
    } seq_t;

    seq_t s_d, s_q;

    logic [IDX_W-1:0] last_byte;
    logic [IDX_W-1:0] tx_ext;
    logic             half_done;

    always_comb begin
        s_d       = s_q;
        buf_we    = 1'b0;
        buf_widx  = '0;
        buf_wdata = s_q.rx_sh;
        tx_ext    = IDX_W'(tx_cnt);
        last_byte = tx_ext + IDX_W'(rx_cnt);
        half_done = (s_q.div == DIV_W'(HALF_DIV - 1));

        unique case (s_q.st)
            SEQ_IDLE: begin
                if (go) begin
                    s_d.st    = SEQ_SHIFT;
                    s_d.cs_n  = 1'b0;
                    s_d.sclk  = 1'b0;
                    s_d.div   = '0;
                    s_d.tx_sh = opcode;
                    s_d.bitn  = '0;
                    s_d.byten = '0;
                end
            end
            SEQ_SHIFT: begin
                if (!half_done) begin
                    s_d.div = s_q.div + 1'b1;
                end else begin
                    s_d.div = '0;
                    if (!s_q.sclk) begin
                        s_d.sclk  = 1'b1;
                        s_d.rx_sh = {s_q.rx_sh[DATA_W-2:0], spi_miso};
                    end else begin
                        s_d.sclk = 1'b0;
                        if (s_q.bitn == BIT_W'(DATA_W - 1)) begin
                            s_d.bitn = '0;
                            if (s_q.byten > tx_ext) begin
                                buf_we   = 1'b1;
                                buf_widx = PTR_W'(s_q.byten - 1'b1);
                            end
                            if (s_q.byten == last_byte) begin
                                s_d.st    = SEQ_IDLE;
                                s_d.cs_n  = 1'b1;
                                s_d.tx_sh = '0;
                            end else begin
                                s_d.byten = s_q.byten + 1'b1;
                                s_d.tx_sh = (s_q.byten < tx_ext) ? buf_rdata : '0;
                            end
                        end else begin
                            s_d.bitn  = s_q.bitn + 1'b1;
                            s_d.tx_sh = {s_q.tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= SEQ_IDLE;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_ridx = PTR_W'(s_q.byten);
    assign busy     = (s_q.st == SEQ_SHIFT);
    assign spi_sclk = s_q.sclk;
    assign spi_cs_n = s_q.cs_n;
    assign spi_mosi = s_q.tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int PTR_W = $clog2(DEPTH);

    logic              busy;
    logic              go;
    logic [DATA_W-1:0] opcode_val;
    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  rx_cnt;
    logic              host_we;
    logic [PTR_W-1:0]  host_ptr;
    logic [DATA_W-1:0] host_rdata;
    logic              eng_we;
    logic [PTR_W-1:0]  eng_widx;
    logic [DATA_W-1:0] eng_wdata;
    logic [PTR_W-1:0]  eng_ridx;
    logic [DATA_W-1:0] eng_rdata;

    spi_cmd_regs #(.DEPTH(DEPTH)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .opcode     (opcode_val),
        .tx_cnt     (tx_cnt),
        .rx_cnt     (rx_cnt),
        .go         (go),
        .host_we    (host_we),
        .host_ptr   (host_ptr),
        .host_rdata (host_rdata)
    );

    spi_cmd_buf #(.DEPTH(DEPTH)) buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (host_ptr),
        .host_wdata (reg_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_widx   (eng_widx),
        .eng_wdata  (eng_wdata),
        .eng_ridx   (eng_ridx),
        .eng_rdata  (eng_rdata)
    );

    spi_cmd_shifter #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .opcode    (opcode_val),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .buf_ridx  (eng_ridx),
        .buf_rdata (eng_rdata),
        .buf_we    (eng_we),
        .buf_widx  (eng_widx),
        .buf_wdata (eng_wdata),
        .busy      (busy),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ctrl,
    input logic             prst_bit,
    input logic             rd_ctrl_go,
    input logic             rd_stat_busy,
    input logic             sel_ctrl,
    input logic             sel_stat,
    input logic             spi_sclk,
    input logic             spi_cs_n,
    input logic             spi_mosi,
    input logic             busy,
    input logic [PTR_W-1:0] host_ptr,
    input logic [7:0]       opcode_val,
    input logic [3:0]       tx_cnt,
    input logic [3:0]       rx_cnt,
    input logic             host_we,
    input logic             eng_we
);

    // R5: lines rest when no command runs
    p_idle_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sclk));

    // R2: output stable across every rising serial edge
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(spi_sclk)) |-> $stable(spi_mosi));

    // R9: configuration frozen during a command
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(opcode_val) && $stable(tx_cnt) && $stable(rx_cnt)));

    // R9: host never writes the buffer while the engine owns it
    p_host_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> (!busy && !eng_we));

    // R4: engine stores only during a command
    p_eng_in_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (busy && !spi_cs_n));

    // R7: pointer clear
    p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && prst_bit && !busy) |=> (host_ptr == '0));

    // R8: status bits mirror the running command
    p_go_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> (rd_ctrl_go == busy));

    p_busy_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stat |-> (rd_stat_busy == busy));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PTR_W($clog2(DEPTH))) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (reg_wr && (reg_addr == 4'h2)),
    .prst_bit     (reg_wdata[4]),
    .rd_ctrl_go   (reg_rdata[0]),
    .rd_stat_busy (reg_rdata[7]),
    .sel_ctrl     (reg_addr == 4'h2),
    .sel_stat     (reg_addr == 4'h3),
    .spi_sclk     (spi_sclk),
    .spi_cs_n     (spi_cs_n),
    .spi_mosi     (spi_mosi),
    .busy         (busy),
    .host_ptr     (host_ptr),
    .opcode_val   (opcode_val),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt),
    .host_we      (host_we),
    .eng_we       (eng_we)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;

    localparam int HALF = 2;
    localparam real TCLK = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.DEPTH(8), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;
    int mon_checks = 0;
    int mon_errs = 0;
    int cmd_bits = 8;
    int rise_total = 0;
    int cs_falls = 0;
    logic [7:0] exp_q[$];
    logic [7:0] resp_q[$];
    logic [7:0] tx_data[8];

    // Scoreboard monitor: compares every sent byte against the expected queue
    logic [7:0] mon_sh = '0;
    int mon_rc = 0;
    realtime last_rise = 0;
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rise_total++;
            mon_rc++;
            if (mon_rc > 1) begin
                mon_checks++;
                if ($realtime - last_rise != 2.0 * HALF * TCLK) begin
                    mon_errs++;
                    $display("FAIL R12 rise spacing act=%0t exp=%0t", $realtime - last_rise, 2.0 * HALF * TCLK);
                end
            end
            last_rise = $realtime;
            mon_sh = {mon_sh[6:0], spi_mosi};
            if (mon_rc % 8 == 0) begin
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_errs++;
                    $display("FAIL R2/R3/R4 mosi byte act=%02h exp=<none>", mon_sh);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (e !== mon_sh) begin
                        mon_errs++;
                        $display("FAIL R2/R3/R4 mosi byte act=%02h exp=%02h", mon_sh, e);
                    end
                end
            end
            if (mon_rc == cmd_bits) mon_rc = 0;
        end
    end

    // Mode-0 device model: drives MISO, changes it on falling edges
    int sl_state = 0;
    int sl_nb = 0;
    logic [7:0] sl_cur = '0;
    always @(negedge spi_cs_n or negedge spi_sclk) begin
        if (sl_state == 0) begin
            if (!spi_cs_n) begin
                cs_falls++;
                sl_state = 1;
                sl_nb = 0;
                sl_cur = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
                spi_miso = sl_cur[7];
            end
        end else begin
            sl_nb++;
            if (sl_nb == cmd_bits) begin
                sl_state = 0;
            end else begin
                if (sl_nb % 8 == 0)
                    sl_cur = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
                spi_miso = sl_cur[7 - (sl_nb % 8)];
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h80;
        while (s[7]) bus_rd(4'h3, s);
    endtask

    // Driver: programs one command and pushes expected bytes into the scoreboard
    task automatic prep_cmd(input logic [7:0] opc, input int ntx, input int nrx,
                            input logic [7:0] resp[16]);
        exp_q.push_back(opc);
        for (int i = 0; i < ntx; i++) exp_q.push_back(tx_data[i % 8]);
        for (int i = 0; i < nrx; i++) exp_q.push_back(8'h00);
        for (int i = 0; i < 1 + ntx + nrx; i++) resp_q.push_back(resp[i]);
        cmd_bits = 8 * (1 + ntx + nrx);
        bus_wr(4'h1, {4'(nrx), 4'(ntx)});
        bus_wr(4'h0, opc);
        bus_wr(4'h2, 8'h10);
        for (int i = 0; i < ntx; i++) bus_wr(4'hC, tx_data[i]);
        bus_wr(4'h2, 8'h10);
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] resp[16];
        int r0, f0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 cs_n", {7'b0, spi_cs_n}, 8'h01);
        check("R1 sclk", {7'b0, spi_sclk}, 8'h00);
        bus_rd(4'h0, rd); check("R1 opcode reg", rd, 8'h00);
        bus_rd(4'h1, rd); check("R1 count reg", rd, 8'h00);
        bus_rd(4'h2, rd); check("R1 ctrl reg", rd, 8'h00);
        bus_rd(4'h3, rd); check("R1 status reg", rd, 8'h00);
        bus_rd(4'hD, rd); check("R1 ptr reg", rd, 8'h00);

        // Command A: tx=3, rx=2 with busy-time writes (R3 R4 R5 R8 R9 R12)
        tx_data = '{8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33; resp[3] = 8'h44;
        resp[4] = 8'h5A; resp[5] = 8'hC3;
        prep_cmd(8'h02, 3, 2, resp);
        bus_wr(4'hC, 8'hA1); bus_wr(4'hC, 8'hB2); bus_wr(4'hC, 8'hC3);
        bus_rd(4'hD, rd); check("R6 ptr after 3 writes", rd, 8'h03);
        r0 = rise_total; f0 = cs_falls;
        bus_wr(4'h2, 8'h01);
        bus_rd(4'h2, rd); check("R8 go bit while running", rd, 8'h01);
        bus_rd(4'h3, rd); check("R8 busy bit while running", rd, 8'h80);
        bus_wr(4'h0, 8'hFF);
        bus_wr(4'h1, 8'h77);
        bus_wr(4'hC, 8'hEE);
        bus_wr(4'h2, 8'h11);
        wait_idle();
        bus_rd(4'h2, rd); check("R8 go bit self-clears", rd, 8'h00);
        bus_rd(4'h0, rd); check("R9 opcode unchanged", rd, 8'h02);
        bus_rd(4'h1, rd); check("R9 counts unchanged", rd, 8'h23);
        bus_rd(4'hD, rd); check("R9 ptr unchanged", rd, 8'h03);
        check("R5 rising edges", 8'(rise_total - r0), 8'd48);
        check("R5 single cs fall", 8'(cs_falls - f0), 8'd1);
        bus_wr(4'h2, 8'h10);
        bus_rd(4'hC, rd); check("R3 entry0 kept", rd, 8'hA1);
        bus_rd(4'hC, rd); check("R3 entry1 kept", rd, 8'hB2);
        bus_rd(4'hC, rd); check("R9 entry2 not overwritten", rd, 8'hC3);
        bus_rd(4'hC, rd); check("R4 rx byte0 at entry3", rd, 8'h5A);
        bus_rd(4'hC, rd); check("R4 rx byte1 at entry4", rd, 8'hC3);

        // Command B: tx=0, rx field 3, host reads 2 (R10)
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        resp[0] = 8'h99; resp[1] = 8'hEF; resp[2] = 8'h40; resp[3] = 8'h18;
        prep_cmd(8'h9F, 0, 3, resp);
        bus_wr(4'h2, 8'h01);
        wait_idle();
        bus_wr(4'h2, 8'h10);
        bus_rd(4'hC, rd); check("R10 first byte at entry0", rd, 8'hEF);
        bus_rd(4'hC, rd); check("R10 second byte at entry1", rd, 8'h40);

        // Command C: tx=6, rx=4, incoming wraps (R11)
        tx_data = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h00, 8'h00};
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        resp[7] = 8'hD0; resp[8] = 8'hD1; resp[9] = 8'hD2; resp[10] = 8'hD3;
        prep_cmd(8'h3B, 6, 4, resp);
        bus_wr(4'h2, 8'h01);
        wait_idle();
        bus_wr(4'h2, 8'h10);
        bus_rd(4'hC, rd); check("R11 entry0 wrapped", rd, 8'hD2);
        bus_rd(4'hC, rd); check("R11 entry1 wrapped", rd, 8'hD3);
        bus_rd(4'hC, rd); check("R11 entry2 tx kept", rd, 8'h32);
        bus_rd(4'hC, rd); check("R11 entry3 tx kept", rd, 8'h43);
        bus_rd(4'hC, rd); check("R11 entry4 tx kept", rd, 8'h54);
        bus_rd(4'hC, rd); check("R11 entry5 tx kept", rd, 8'h65);
        bus_rd(4'hC, rd); check("R11 entry6 rx", rd, 8'hD0);
        bus_rd(4'hC, rd); check("R11 entry7 rx", rd, 8'hD1);
        bus_rd(4'hD, rd); check("R6 ptr wraps to 0", rd, 8'h00);

        // R7 pointer clear
        bus_rd(4'hC, rd); bus_rd(4'hC, rd);
        bus_rd(4'hD, rd); check("R6 ptr after 2 reads", rd, 8'h02);
        bus_wr(4'h2, 8'h10);
        bus_rd(4'hD, rd); check("R7 ptr cleared", rd, 8'h00);

        // Command D: opcode only (R2 R5)
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        r0 = rise_total;
        prep_cmd(8'h06, 0, 0, resp);
        bus_wr(4'h2, 8'h01);
        wait_idle();
        check("R5 opcode-only edges", 8'(rise_total - r0), 8'd8);
        check("R1 cs_n high after", {7'b0, spi_cs_n}, 8'h01);
        check("R2 scoreboard drained", 8'(exp_q.size()), 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

endmodule